// File: doc/BRIEF.md
# Video Line and Field Counter with Trick-Play Resync

This block produces the line and field timing for a standard-definition video encoder. A line ends after a set number of qualified pixel-clock enables. A frame holds 525 lines in the 60 Hz standard and 625 lines in the 50 Hz standard, selected by an input pin. The frame is split into two fields. The block reports the current line number, which field is active, and a one-cycle start-of-field strobe.

When the encoder is a timing slave, an incoming VSYNC marks where each field of the source video ends. Fast-forward material brings that mark too early and rewind material brings it too late. With resync off, the counters keep free-running and the incoming mark raises its own start-of-field strobe, so two boundaries compete. With resync on, and only in slave modes 1 and 2, the counters follow the incoming mark instead. An early mark cuts the field short at the next line end. A late mark keeps the counter on the field's last line until the mark arrives. Either way exactly one boundary is produced per field.

Top module: `sd_field_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `line_no` is 1, `field_o` is 0 and `sof_o` is 0.
- R2: `line_no` advances only on a clock edge that completes LINE_CLKS edges with `pix_en` high. While `pix_en` is low, `line_no`, `field_o` and the pixel position hold.
- R3: The frame total T is NTSC_LINES when `std_pal`=0 and PAL_LINES when `std_pal`=1, and F0=(T+1)/2. Field 0 (`field_o`=0) covers lines 1..F0 and field 1 covers lines F0+1..T. When free-running, line F0 is followed by line F0+1 and line T is followed by line 1.
- R4: When a field boundary is taken, `sof_o` is high for the one cycle after that clock edge, and in that cycle `line_no` is the first line of the new field (1 or F0+1).
- R5: In master mode (`timing_mode`=00) the `vsync_in` input has no effect on `line_no`, `field_o` or `sof_o`.
- R6: In a slave mode (`timing_mode` 01, 10 or 11) with resync inactive, the counters free-run as in R3. Each rising edge of `vsync_in` also raises `sof_o` for the cycle after the edge is sampled, and leaves `line_no` and `field_o` unchanged.
- R7: Resync is active only when `resync_en`=1 and `timing_mode` is 10 or 11. With `timing_mode`=01, `resync_en` is ignored and the block behaves as in R6.
- R8: With resync active, a `vsync_in` rising edge seen before the current line ends causes the next line end to jump to the first line of the other field, toggle `field_o` and pulse `sof_o`, even if the field's last line was not reached.
- R9: With resync active, when the last line of a field (F0 or T) ends with no `vsync_in` edge pending, `line_no` and `field_o` hold and `sof_o` stays low. The first line end after the next `vsync_in` edge then advances to the next field.
- R10: With resync active, `sof_o` never pulses on the `vsync_in` edge itself. It pulses exactly once per output field, at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable qualifying each clock edge |
| vsync_in | input | 1 | Incoming field-end mark; rising edge is the event |
| resync_en | input | 1 | Requests that the counters follow `vsync_in` |
| timing_mode | input | 2 | 00 master, 01 slave 0, 10 slave 1, 11 slave 2 |
| std_pal | input | 1 | 0 selects the 525-line total, 1 the 625-line total |
| line_no | output | clog2(max(NTSC_LINES,PAL_LINES)+1) | Current frame line number, starting at 1 |
| field_o | output | 1 | Current field: 0 first, 1 second |
| sof_o | output | 1 | One-cycle start-of-field strobe |

## Verification
The assertions assume that `std_pal`, `timing_mode` and `resync_en` change only while `rst` is high, and that LINE_CLKS is at least 2 so that line ends are never on back-to-back edges. The bench therefore sets the configuration inside each reset sequence and never changes it during a run. `vsync_in` is driven as short pulses on falling clock edges, always well apart from each other, with the line ends and expected outputs counted from the number of edges since reset.

// File: rtl/sd_ft_pkg.sv
package sd_ft_pkg;

  // Timing mode encoding; bit 1 set means a slave mode that may resync
  typedef enum logic [1:0] {
    TM_MASTER = 2'b00,
    TM_SLAVE0 = 2'b01,
    TM_SLAVE1 = 2'b10,
    TM_SLAVE2 = 2'b11
  } tmode_e;

endpackage

// File: rtl/sd_ft_pixel_div.sv
// Counts qualified pixel enables and flags the edge that closes a line.
module sd_ft_pixel_div #(
  parameter int LINE_CLKS = 858
) (
  input  logic clk,
  input  logic rst,
  input  logic pix_en,
  output logic line_end
);
  localparam int PW = (LINE_CLKS > 2) ? $clog2(LINE_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(LINE_CLKS - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (pix_en) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign line_end = pix_en && (cnt_q == LAST);

endmodule

// File: rtl/sd_ft_vsync_track.sv
// Detects incoming VSYNC rising edges and keeps one pending until the
// next line end consumes it (only while resync is active).
module sd_ft_vsync_track (
  input  logic clk,
  input  logic rst,
  input  logic vsync_in,
  input  logic track_en,
  input  logic line_end,
  output logic vs_edge,
  output logic pend_hit
);
  logic vs_d;
  logic pend_q;

  assign vs_edge  = vsync_in & ~vs_d;
  assign pend_hit = pend_q | vs_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_d   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      vs_d <= vsync_in;
      if (!track_en || line_end) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_hit;
      end
    end
  end

endmodule

// File: rtl/sd_ft_line_field.sv
// Line and field counters with free-run and resync policies.
module sd_ft_line_field #(
  parameter int NTSC_LINES = 525,
  parameter int PAL_LINES  = 625,
  parameter int LW         = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic          std_pal,
  input  logic          track_en,
  input  logic          pend_hit,
  input  logic          marker,
  output logic [LW-1:0] line_no,
  output logic          field_o,
  output logic          sof_o
);
  localparam logic [LW-1:0] NT_TOT = LW'(NTSC_LINES);
  localparam logic [LW-1:0] NT_F0  = LW'((NTSC_LINES + 1) / 2);
  localparam logic [LW-1:0] PA_TOT = LW'(PAL_LINES);
  localparam logic [LW-1:0] PA_F0  = LW'((PAL_LINES + 1) / 2);
  localparam logic [LW-1:0] ONE    = LW'(1);

  logic [LW-1:0] line_q, line_n;
  logic          field_q, field_n;
  logic          sof_q, sof_n;
  logic [LW-1:0] tot, f0_end, next_first;
  logic          at_last;

  always_comb begin
    tot        = std_pal ? PA_TOT : NT_TOT;
    f0_end     = std_pal ? PA_F0 : NT_F0;
    at_last    = field_q ? (line_q >= tot) : (line_q >= f0_end);
    next_first = field_q ? ONE : f0_end + ONE;
  end

  always_comb begin
    line_n  = line_q;
    field_n = field_q;
    sof_n   = marker;
    if (line_end) begin
      if (track_en) begin
        if (pend_hit) begin
          line_n  = next_first;
          field_n = ~field_q;
          sof_n   = 1'b1;
        end else if (!at_last) begin
          line_n = line_q + ONE;
        end
      end else if (at_last) begin
        line_n  = next_first;
        field_n = ~field_q;
        sof_n   = 1'b1;
      end else begin
        line_n = line_q + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= ONE;
      field_q <= 1'b0;
      sof_q   <= 1'b0;
    end else begin
      line_q  <= line_n;
      field_q <= field_n;
      sof_q   <= sof_n;
    end
  end

  assign line_no = line_q;
  assign field_o = field_q;
  assign sof_o   = sof_q;

endmodule

// File: rtl/sd_field_timer.sv
module sd_field_timer
  import sd_ft_pkg::*;
#(
  parameter int LINE_CLKS  = 858,
  parameter int NTSC_LINES = 525,
  parameter int PAL_LINES  = 625,
  localparam int MAXL      = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES,
  localparam int LW        = $clog2(MAXL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          vsync_in,
  input  logic          resync_en,
  input  logic [1:0]    timing_mode,
  input  logic          std_pal,
  output logic [LW-1:0] line_no,
  output logic          field_o,
  output logic          sof_o
);
  tmode_e mode;
  logic   is_slave;
  logic   resync_act;
  logic   line_end;
  logic   vs_edge;
  logic   pend_hit;
  logic   marker;

  always_comb begin
    mode       = tmode_e'(timing_mode);
    is_slave   = (mode != TM_MASTER);
    resync_act = resync_en && ((mode == TM_SLAVE1) || (mode == TM_SLAVE2));
    marker     = vs_edge && is_slave && !resync_act;
  end

  sd_ft_pixel_div #(.LINE_CLKS(LINE_CLKS)) u_pix (
    .clk      (clk),
    .rst      (rst),
    .pix_en   (pix_en),
    .line_end (line_end)
  );

  sd_ft_vsync_track u_vs (
    .clk      (clk),
    .rst      (rst),
    .vsync_in (vsync_in),
    .track_en (resync_act),
    .line_end (line_end),
    .vs_edge  (vs_edge),
    .pend_hit (pend_hit)
  );

  sd_ft_line_field #(
    .NTSC_LINES (NTSC_LINES),
    .PAL_LINES  (PAL_LINES),
    .LW         (LW)
  ) u_lf (
    .clk      (clk),
    .rst      (rst),
    .line_end (line_end),
    .std_pal  (std_pal),
    .track_en (resync_act),
    .pend_hit (pend_hit),
    .marker   (marker),
    .line_no  (line_no),
    .field_o  (field_o),
    .sof_o    (sof_o)
  );

endmodule

// File: rtl/sd_field_timer_chk.sv
module sd_field_timer_chk #(
  parameter int LINE_CLKS  = 858,
  parameter int NTSC_LINES = 525,
  parameter int PAL_LINES  = 625,
  parameter int LW         = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic          resync_en,
  input logic [1:0]    timing_mode,
  input logic          std_pal,
  input logic [LW-1:0] line_no,
  input logic          field_o,
  input logic          sof_o
);
  logic [LW-1:0] tot_c, f0_c;
  logic          act_c, master_c, first_c;

  always_comb begin
    tot_c    = std_pal ? LW'(PAL_LINES) : LW'(NTSC_LINES);
    f0_c     = std_pal ? LW'((PAL_LINES + 1) / 2) : LW'((NTSC_LINES + 1) / 2);
    act_c    = resync_en && timing_mode[1];
    master_c = (timing_mode == 2'b00);
    first_c  = (line_no == LW'(1)) || (line_no == f0_c + LW'(1));
  end

  // R3
  line_range_chk: assert property (@(posedge clk) disable iff (rst)
    (line_no >= LW'(1)) && (line_no <= tot_c));

  // R3
  field_map_chk: assert property (@(posedge clk) disable iff (rst)
    field_o == (line_no > f0_c));

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable(line_no) && $stable(field_o));

  // R4
  sof_first_chk: assert property (@(posedge clk) disable iff (rst)
    sof_o && (master_c || act_c) |-> first_c);

  generate
    if (LINE_CLKS > 1) begin : g_single
      // R10
      sof_single_chk: assert property (@(posedge clk) disable iff (rst)
        sof_o && act_c |=> !sof_o);
    end
  endgenerate

endmodule

bind sd_field_timer sd_field_timer_chk #(
  .LINE_CLKS  (LINE_CLKS),
  .NTSC_LINES (NTSC_LINES),
  .PAL_LINES  (PAL_LINES),
  .LW         (LW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pix_en      (pix_en),
  .resync_en   (resync_en),
  .timing_mode (timing_mode),
  .std_pal     (std_pal),
  .line_no     (line_no),
  .field_o     (field_o),
  .sof_o       (sof_o)
);

// File: tb/sd_field_timer_tb.sv
`timescale 1ns/1ps
module sd_field_timer_tb;
  localparam int LC = 3;
  localparam int NT = 11;
  localparam int PA = 13;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b1;
  logic vsync_in = 1'b0;
  logic resync_en = 1'b0;
  logic [1:0] timing_mode = 2'b00;
  logic std_pal = 1'b0;
  logic [LW-1:0] line_no;
  logic field_o;
  logic sof_o;

  int total = 0;
  int bad = 0;
  int edges = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  sd_field_timer #(
    .LINE_CLKS(LC), .NTSC_LINES(NT), .PAL_LINES(PA)
  ) u_dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .vsync_in(vsync_in),
    .resync_en(resync_en), .timing_mode(timing_mode), .std_pal(std_pal),
    .line_no(line_no), .field_o(field_o), .sof_o(sof_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at edge %0d: act=%0d exp=%0d", tag, edges, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    edges++;
  endtask

  task automatic run_to(input int e);
    while (edges < e) step();
  endtask

  task automatic do_reset(input logic pal, input logic [1:0] mode, input logic rs);
    @(negedge clk);
    rst = 1'b1;
    std_pal = pal;
    timing_mode = mode;
    resync_en = rs;
    pix_en = 1'b1;
    vsync_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 line", int'(line_no), 1);
    check("R1 field", int'(field_o), 0);
    check("R1 sof", int'(sof_o), 0);
    rst = 1'b0;
    edges = 0;
  endtask

  // vsync high for exactly the edge after the current one
  task automatic pulse_vs();
    vsync_in = 1'b1;
    step();
    vsync_in = 1'b0;
  endtask

  // free-running sweep over two frames, every edge checked arithmetically
  task automatic sweep(input logic pal, input logic [1:0] mode);
    int t, f0;
    t  = pal ? PA : NT;
    f0 = (t + 1) / 2;
    do_reset(pal, mode, 1'b0);
    for (int e = 0; e <= 2 * t * LC + 2; e++) begin
      int l, s;
      l = (e / LC) % t + 1;
      s = (e > 0 && e % LC == 0 && (l == 1 || l == f0 + 1)) ? 1 : 0;
      if (e > 0) step();
      check("R3 line", int'(line_no), l);
      check("R3 field", int'(field_o), (l > f0) ? 1 : 0);
      check("R4 sof", int'(sof_o), s);
    end
  endtask

  initial begin
    int sofs;
    // R1 R3 R4: both standards, master and slave without vsync
    sweep(1'b0, 2'b00);
    sweep(1'b1, 2'b00);
    sweep(1'b1, 2'b11);

    // R2: pix_en low holds, sparse pix_en advances after LC enables
    do_reset(1'b0, 2'b00, 1'b0);
    pix_en = 1'b0;
    run_to(8);
    check("R2 hold line", int'(line_no), 1);
    pix_en = 1'b1;
    run_to(11);
    check("R2 resume", int'(line_no), 2);
    for (int k = 0; k < 5; k++) begin
      pix_en = (k % 2 == 0);
      step();
      if (k == 3) check("R2 sparse before", int'(line_no), 2);
    end
    check("R2 sparse after", int'(line_no), 3);
    pix_en = 1'b1;

    // R6: slave 1 without resync, vsync gives an extra strobe only
    do_reset(1'b0, 2'b10, 1'b0);
    run_to(6);
    pulse_vs();
    check("R6 marker sof", int'(sof_o), 1);
    check("R6 line kept", int'(line_no), 3);
    step();
    check("R6 sof drops", int'(sof_o), 0);
    run_to(9);
    check("R6 free run", int'(line_no), 4);
    check("R6 field kept", int'(field_o), 0);

    // R7: slave 0 ignores resync_en
    do_reset(1'b0, 2'b01, 1'b1);
    run_to(6);
    pulse_vs();
    check("R7 marker sof", int'(sof_o), 1);
    run_to(9);
    check("R7 no jump", int'(line_no), 4);

    // R5: master ignores vsync even with resync_en set
    do_reset(1'b0, 2'b00, 1'b1);
    run_to(6);
    pulse_vs();
    check("R5 no sof", int'(sof_o), 0);
    run_to(9);
    check("R5 no jump", int'(line_no), 4);
    check("R5 field", int'(field_o), 0);

    // R8 R9 R10: slave 2 with resync, NTSC small total 11, F0 6
    do_reset(1'b0, 2'b11, 1'b1);
    run_to(6);
    pulse_vs();
    check("R10 no sof on edge", int'(sof_o), 0);
    check("R8 line before", int'(line_no), 3);
    run_to(9);
    check("R8 early jump line", int'(line_no), 7);
    check("R8 early field", int'(field_o), 1);
    check("R8 early sof", int'(sof_o), 1);
    step();
    check("R10 sof one cycle", int'(sof_o), 0);
    run_to(24);
    check("R9 hold line", int'(line_no), 11);
    check("R9 hold sof", int'(sof_o), 0);
    run_to(30);
    check("R9 still held", int'(line_no), 11);
    check("R9 field held", int'(field_o), 1);
    run_to(31);
    pulse_vs();
    run_to(33);
    check("R9 late advance line", int'(line_no), 1);
    check("R9 late field", int'(field_o), 0);
    check("R9 late sof", int'(sof_o), 1);
    sofs = 0;
    while (edges < 53) begin
      if (edges == 48) pulse_vs(); else step();
      if (sof_o) sofs++;
      if (edges == 51) check("R10 on-time line", int'(line_no), 7);
    end
    check("R10 one sof per field", sofs, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule